// File: doc/BRIEF.md
# UART Baud Tick Generator

This block produces the timing strobes for a serial port with four rate modes. In mode 0 and mode 2 the rate is a fixed fraction of the oscillator-rate enable. In mode 0 a bit lasts 16 enabled cycles. In mode 2 a bit lasts 32 enabled cycles. In mode 1 and mode 3 the rate comes from an auto-reloading timer. A prescaler divides the oscillator enable by 4, 16 or 64 before it reaches the timer. The timer is either 8 or 16 bits wide, and each overflow of the timer is one oversampling tick. A bit time is always sixteen oversampling ticks.

The transmit and receive sides each get their own oversampling tick (`*_tick16`) and their own one-cycle bit strobe (`*_bit`). In the timer modes, each side picks on its own whether it follows the internal timer or an external overflow strobe (`alt_ovf`). The two sides can therefore run at different rates. When `run` is low, every counter is cleared, the timer is preloaded with the reload value and all strobes stay low. While the enable is low, nothing advances.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst_n` is low, and in every cycle that follows a cycle with `run` low, all four tick outputs are 0.
- R2: Mode 0 (`mode`=0): each `*_tick16` pulses one cycle after every enabled cycle. Each `*_bit` pulses once per 16 enabled cycles.
- R3: Mode 2 (`mode`=2): each `*_tick16` pulses once per 2 enabled cycles, so it is never high two cycles in a row. Each `*_bit` pulses once per 32 enabled cycles.
- R4: The prescaler divides the enable by 4 when `presc_sel`=0, by 16 when it is 1, and by 64 when it is 2 or 3.
- R5: With `wide_sel`=0 the timer counts over 256 states. Only `reload[7:0]` is used. Overflows come every N*(256-reload[7:0]) enabled cycles, where N is the prescale factor. A reload of 0 gives the slowest rate.
- R6: With `wide_sel`=1 the timer counts over 65536 states. Overflows come every N*(65536-reload) enabled cycles.
- R7: In mode 1 and mode 3 (`mode[0]`=1) with the timer selected, `*_tick16` follows the timer overflow. Overflows are at least 4 enabled cycles apart, so the tick is never high in two consecutive cycles.
- R8: `tx_src_sel`/`rx_src_sel`=1 selects the timer and 0 selects `alt_ovf`, for each side independently. The selection matters only in mode 1 and mode 3. In mode 0 and mode 2, `alt_ovf` has no effect.
- R9: Each `*_bit` is high only in a cycle where the same side's `*_tick16` is high. It pulses once per 16 of those ticks and lasts one cycle.
- R10: When `osc_en` is low and `alt_ovf` is low, no tick appears in the next cycle. Running the enable at half rate doubles every period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | Oscillator-rate enable, one pulse per oscillator period |
| run | input | 1 | High to run; low clears all counters and silences the ticks |
| mode | input | 2 | Rate mode 0..3 |
| presc_sel | input | 2 | Prescaler select: 0 = /4, 1 = /16, 2 or 3 = /64 |
| wide_sel | input | 1 | 1 = 16-bit timer, 0 = 8-bit timer |
| reload | input | 16 | Timer reload value |
| tx_src_sel | input | 1 | Transmit side source: 1 = timer, 0 = alt_ovf |
| rx_src_sel | input | 1 | Receive side source: 1 = timer, 0 = alt_ovf |
| alt_ovf | input | 1 | External overflow strobe from another timer |
| tx_tick16 | output | 1 | Transmit oversampling tick |
| tx_bit | output | 1 | Transmit bit-time strobe |
| rx_tick16 | output | 1 | Receive oversampling tick |
| rx_bit | output | 1 | Receive bit-time strobe |

## Verification
Several properties are checked on every cycle:
- the silence that follows a cycle with `run` low, and the stall when `osc_en` and `alt_ovf` are both low;
- the rule that a bit strobe coincides with a tick;
- the single-cycle width of the bit strobe;
- the cycle-by-cycle rhythm of mode 0 and mode 2;
- the spacing of ticks that come from the timer.

Exact periods can only be shown by the bench scenarios, which measure the distance between successive pulses. These periods cover the prescale factors, both timer widths with their reload arithmetic (the slowest reload of 0 included), independent per-side source selection and half-rate enables.

// File: rtl/baud_pkg.sv
package baud_pkg;

  typedef enum logic [1:0] {
    MODE_FIX16 = 2'd0,
    MODE_TMR_A = 2'd1,
    MODE_FIX32 = 2'd2,
    MODE_TMR_B = 2'd3
  } baud_mode_e;

  // Terminal count of the prescaler for a select code (factor minus one).
  function automatic logic [5:0] presc_limit(input logic [1:0] sel);
    case (sel)
      2'd0:    presc_limit = 6'd3;
      2'd1:    presc_limit = 6'd15;
      default: presc_limit = 6'd63;
    endcase
  endfunction

endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler
  import baud_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       osc_en,
  input  logic [1:0] presc_sel,
  output logic       presc_tick
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] limit;

  always_comb begin
    limit      = CNT_W'(presc_limit(presc_sel));
    presc_tick = run && osc_en && (cnt_q >= limit);
    cnt_d      = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (osc_en) begin
      cnt_d = presc_tick ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/baud_reload_timer.sv
module baud_reload_timer #(
  parameter int TMR_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             step,
  input  logic             wide_sel,
  input  logic [TMR_W-1:0] reload,
  output logic             ovf
);

  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic [TMR_W-1:0] reload_eff;
  logic             at_top;

  always_comb begin
    reload_eff = wide_sel ? reload : {{(TMR_W-NARROW_W){1'b0}}, reload[NARROW_W-1:0]};
    at_top     = wide_sel ? (&cnt_q) : (&cnt_q[NARROW_W-1:0]);
    ovf        = run && step && at_top;
    cnt_d      = cnt_q;
    if (!run) begin
      cnt_d = reload_eff;
    end else if (step) begin
      // reload in the overflow cycle itself: no count is lost
      cnt_d = at_top ? reload_eff : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/baud_dir_divider.sv
module baud_dir_divider
  import baud_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       osc_en,
  input  logic [1:0] mode,
  input  logic       src_sel,
  input  logic       tmr_ovf,
  input  logic       alt_ovf,
  output logic       tick16,
  output logic       bit_stb
);

  localparam int DIV_W = $clog2(OVS);

  logic             half_q, half_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             tick_q, tick_d;
  logic             bit_q, bit_d;
  logic             raw;

  always_comb begin
    half_d = half_q;
    raw    = 1'b0;
    case (baud_mode_e'(mode))
      MODE_FIX16: raw = osc_en;
      MODE_FIX32: begin
        raw = osc_en && half_q;
        if (osc_en) half_d = ~half_q;
      end
      default:    raw = src_sel ? tmr_ovf : alt_ovf;
    endcase
    raw = raw && run;

    div_d = div_q;
    if (raw) div_d = div_q + 1'b1;
    bit_d  = raw && (div_q == DIV_W'(OVS-1));
    tick_d = raw;

    if (!run) begin
      half_d = 1'b0;
      div_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      div_q  <= '0;
      tick_q <= 1'b0;
      bit_q  <= 1'b0;
    end else begin
      half_q <= half_d;
      div_q  <= div_d;
      tick_q <= tick_d;
      bit_q  <= bit_d;
    end
  end

  assign tick16  = tick_q;
  assign bit_stb = bit_q;

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int TMR_W    = 16,
  parameter int NARROW_W = 8,
  parameter int OVS      = 16,
  parameter int PRESC_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic             run,
  input  logic [1:0]       mode,
  input  logic [1:0]       presc_sel,
  input  logic             wide_sel,
  input  logic [TMR_W-1:0] reload,
  input  logic             tx_src_sel,
  input  logic             rx_src_sel,
  input  logic             alt_ovf,
  output logic             tx_tick16,
  output logic             tx_bit,
  output logic             rx_tick16,
  output logic             rx_bit
);

  localparam int N_DIR = 2;

  logic             presc_tick;
  logic             tmr_ovf;
  logic [N_DIR-1:0] dir_sel;
  logic [N_DIR-1:0] dir_tick;
  logic [N_DIR-1:0] dir_bit;

  assign dir_sel = {rx_src_sel, tx_src_sel};

  baud_prescaler #(.CNT_W(PRESC_W)) u_presc (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .osc_en     (osc_en),
    .presc_sel  (presc_sel),
    .presc_tick (presc_tick)
  );

  baud_reload_timer #(.TMR_W(TMR_W), .NARROW_W(NARROW_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .step     (presc_tick),
    .wide_sel (wide_sel),
    .reload   (reload),
    .ovf      (tmr_ovf)
  );

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    baud_dir_divider #(.OVS(OVS)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .osc_en  (osc_en),
      .mode    (mode),
      .src_sel (dir_sel[d]),
      .tmr_ovf (tmr_ovf),
      .alt_ovf (alt_ovf),
      .tick16  (dir_tick[d]),
      .bit_stb (dir_bit[d])
    );
  end

  assign tx_tick16 = dir_tick[0];
  assign tx_bit    = dir_bit[0];
  assign rx_tick16 = dir_tick[1];
  assign rx_bit    = dir_bit[1];

endmodule

// File: rtl/baud_tick_checker.sv
module baud_tick_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic       osc_en,
  input logic       alt_ovf,
  input logic [1:0] mode,
  input logic       tx_src_sel,
  input logic       tx_tick16,
  input logic       tx_bit,
  input logic       rx_tick16,
  input logic       rx_bit
);

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |-> (!tx_tick16 && !tx_bit && !rx_tick16 && !rx_bit));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!tx_tick16 && !tx_bit && !rx_tick16 && !rx_bit));

  p_mode0_rate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && osc_en && mode == 2'd0) |=> (tx_tick16 && rx_tick16));

  p_mode2_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tick16 && run && mode == 2'd2 && $past(run && mode == 2'd2)) |=> !tx_tick16);

  p_timer_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tick16 && run && mode[0] && tx_src_sel && $past(run && mode[0] && tx_src_sel))
      |=> !tx_tick16);

  p_bit_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_bit -> tx_tick16) && (rx_bit -> rx_tick16));

  p_bit_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_bit || rx_bit) |=> (!tx_bit && !rx_bit));

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && !alt_ovf) |=> (!tx_tick16 && !rx_tick16));

endmodule

bind baud_tick_gen baud_tick_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .osc_en     (osc_en),
  .alt_ovf    (alt_ovf),
  .mode       (mode),
  .tx_src_sel (tx_src_sel),
  .tx_tick16  (tx_tick16),
  .tx_bit     (tx_bit),
  .rx_tick16  (rx_tick16),
  .rx_bit     (rx_bit)
);

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_en = 1'b1;
  logic        run = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [1:0]  presc_sel = 2'd0;
  logic        wide_sel = 1'b0;
  logic [15:0] reload = 16'd0;
  logic        tx_src_sel = 1'b1;
  logic        rx_src_sel = 1'b1;
  logic        alt_ovf = 1'b0;
  logic        tx_tick16, tx_bit, rx_tick16, rx_bit;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic osc_half = 1'b0;
  logic alt_on   = 1'b0;

  always #4 clk = ~clk;   // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  baud_tick_gen dut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .run(run), .mode(mode),
    .presc_sel(presc_sel), .wide_sel(wide_sel), .reload(reload),
    .tx_src_sel(tx_src_sel), .rx_src_sel(rx_src_sel), .alt_ovf(alt_ovf),
    .tx_tick16(tx_tick16), .tx_bit(tx_bit), .rx_tick16(rx_tick16), .rx_bit(rx_bit)
  );

  // input drivers for enable pattern and external overflow strobe
  initial begin
    int acnt = 0;
    forever begin
      @(negedge clk);
      osc_en = osc_half ? ~osc_en : 1'b1;
      if (alt_on) begin
        acnt    = (acnt + 1) % 5;
        alt_ovf = (acnt == 0);
      end else begin
        acnt    = 0;
        alt_ovf = 1'b0;
      end
    end
  end

  // mode, presc, wide, reload, tick16 period, bit period (osc_en always high, timer source)
  localparam int NV = 8;
  localparam int V_MODE [NV] = '{0, 2, 1, 3, 1, 1, 3, 1};
  localparam int V_PSEL [NV] = '{0, 0, 0, 1, 3, 0, 0, 2};
  localparam int V_WIDE [NV] = '{0, 0, 0, 0, 0, 1, 0, 1};
  localparam int V_RLD  [NV] = '{0, 0, 'h00FF, 'h00FE, 'h00FC, 'hFFF0, 'h1200, 'hFFFE};
  localparam int V_P16  [NV] = '{1, 2, 4, 32, 256, 64, 1024, 128};
  localparam int V_PBIT [NV] = '{16, 32, 64, 512, 4096, 1024, 16384, 2048};

  function automatic logic sig(input int w);
    case (w)
      0: sig = tx_tick16;
      1: sig = tx_bit;
      2: sig = rx_tick16;
      default: sig = rx_bit;
    endcase
  endfunction

  task automatic period_of(input int w, output int per);
    int t1 = -1;
    per = -1;
    while (per < 0) begin
      @(negedge clk);
      if (sig(w)) begin
        if (t1 < 0) t1 = cyc;
        else per = cyc - t1;
      end
    end
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic restart();
    @(negedge clk);
    run = 1'b0;
    repeat (2) @(negedge clk);
    run = 1'b1;
  endtask

  task automatic count_pulses(input int n, output int cnt);
    cnt = 0;
    repeat (n) begin
      @(negedge clk);
      cnt += int'(tx_tick16) + int'(tx_bit) + int'(rx_tick16) + int'(rx_bit);
    end
  endtask

  task automatic measure_all(input string req, input int e16_tx, input int ebit_tx,
                             input int e16_rx, input int ebit_rx);
    int p;
    period_of(0, p); check(req, "tx tick16 period", p, e16_tx);
    period_of(1, p); check(req, "tx bit period", p, ebit_tx);
    period_of(2, p); check(req, "rx tick16 period", p, e16_rx);
    period_of(3, p); check(req, "rx bit period", p, ebit_rx);
  endtask

  initial begin
    int n;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "ticks during reset", int'(tx_tick16) + int'(tx_bit) + int'(rx_tick16) + int'(rx_bit), 0);
    rst_n = 1'b1;
    count_pulses(40, n);
    check("R1", "ticks with run low", n, 0);

    // table: R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      mode      = V_MODE[i][1:0];
      presc_sel = V_PSEL[i][1:0];
      wide_sel  = V_WIDE[i][0];
      reload    = V_RLD[i][15:0];
      restart();
      measure_all($sformatf("R2/R3/R4/R5/R6/R7/R9 vec%0d", i),
                  V_P16[i], V_PBIT[i], V_P16[i], V_PBIT[i]);
    end

    // R8: rx follows alt_ovf (every 5 cycles), tx stays on timer (4*(256-253)=12)
    mode = 2'd1; presc_sel = 2'd0; wide_sel = 1'b0; reload = 16'h00FD;
    rx_src_sel = 1'b0; alt_on = 1'b1;
    restart();
    measure_all("R8 split sources", 12, 192, 5, 80);

    // R8: tx on alt, rx on timer
    tx_src_sel = 1'b0; rx_src_sel = 1'b1;
    restart();
    measure_all("R8 swapped sources", 5, 80, 12, 192);

    // R8: alt_ovf ignored in mode 0
    mode = 2'd0;
    restart();
    measure_all("R8 alt ignored mode0", 1, 16, 1, 16);
    alt_on = 1'b0; tx_src_sel = 1'b1; rx_src_sel = 1'b1;

    // R10: half-rate enable doubles periods (mode 0 and mode 2)
    osc_half = 1'b1;
    restart();
    measure_all("R10 half enable mode0", 2, 32, 2, 32);
    mode = 2'd2;
    restart();
    measure_all("R10 half enable mode2", 4, 64, 4, 64);
    osc_half = 1'b0;

    // R1: dropping run silences the outputs from the next cycle on
    mode = 2'd0;
    restart();
    repeat (20) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    count_pulses(30, n);
    check("R1", "ticks after run drop", n, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule